// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This block turns a 16-bit segment selector into a cached segment descriptor. A command carries a selector and either names one of several segment cache slots or asks for the local table register to be reloaded. The block splits the selector into its privilege, table and index fields. It picks the global or the local descriptor table, checks that the whole 8-byte entry lies inside that table's limit, and reads the entry from memory as two 32-bit words. The decoded base, limit and attribute fields then go into the chosen slot.

The global table register is a plain 48-bit value that can be written in any cycle. The local table register is a selector into the global table, together with a cached base and limit. Reloading it fetches its own descriptor from the global table. Faults are reported as a one-cycle pulse, and no state changes on a fault.

Commands enter on a valid/ready port. `cmd_ready` is high only while no fetch is in flight. A command is taken on the edge where `cmd_valid` and `cmd_ready` are both high. A command held while the block is busy waits untouched. Memory reads leave on a valid/ready request port. `mem_req_valid` and `mem_req_addr` stay fixed until `mem_req_ready` is seen. At most one read is outstanding. Its single response (`mem_rsp_valid` for one cycle) must come at least one cycle after the request handshake and is always accepted.

Top module: `seg_desc_fetch`

## Requirements
- R1: Selector bits [1:0] are the requested privilege level (0 most privileged, 3 least) and are reported unchanged on `seg_rd_rpl`. Bit 2 picks the table (0 global, 1 local). Bits [15:3] are the entry index.
- R2: A global-table entry lives at global base + index*8. It is read as two requests: first that address (low word), then that address + 4 (high word).
- R3: A local-table entry lives at cached local base + index*8. Its bound check uses the cached local limit.
- R4: The low word is the 32-bit segment base. In the high word, bits [19:0] are the 20-bit segment limit and bits [31:20] are the 12-bit attribute field, whose lowest bit (word bit 20) is the granularity flag. The slot holds the loaded selector and these fields. It updates on the edge where the second word arrives, and `done` pulses for the following cycle.
- R5: If index*8 + 7 exceeds the selected table's limit, the block issues no read. `fault` then pulses in the cycle after acceptance, and no slot or local table state changes.
- R6: A local-table command while the local table register's index (bits [15:3]) is zero raises the same fault as R5, with no read.
- R7: A local-table-register load always indexes the global table, whatever bit 2 holds. On completion the register takes the selector, the descriptor base, and the low 16 bits of the descriptor limit.
- R8: A local-table-register load with index zero issues no read. It stores the selector, clears the cached base and limit, and pulses `done` in the cycle after acceptance.
- R9: A global register write loads limit from `gtr_wdata[15:0]` and base from `gtr_wdata[47:16]`. It takes effect from the next cycle. A command accepted in the same cycle uses the previous value.
- R10: `mem_req_valid` and `mem_req_addr` hold steady while `mem_req_ready` is low. One read is outstanding at a time.
- R11: `cmd_ready` is low from acceptance of a fetching command until `done`. A command held during that time is taken exactly once, after `done`.
- R12: After reset, all slots, the local table register and the global register are zero, `cmd_ready` is high and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gtr_we | input | 1 | Write strobe for the global table register |
| gtr_wdata | input | 48 | Global table register value: [47:16] base, [15:0] limit |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_ltr | input | 1 | 1: reload local table register, 0: load a segment slot |
| cmd_seg | input | SEG_IDX_W (3) | Target slot for a segment load |
| cmd_sel | input | 16 | Selector to load |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| seg_rd_idx | input | SEG_IDX_W (3) | Slot selected for readout |
| seg_rd_sel | output | 16 | Selector held in that slot |
| seg_rd_rpl | output | 2 | Requested privilege level of that slot |
| seg_rd_base | output | 32 | Cached segment base |
| seg_rd_limit | output | 20 | Cached segment limit |
| seg_rd_gran | output | 1 | Cached granularity flag |
| seg_rd_attr | output | 12 | Cached attribute field |
| ldt_sel | output | 16 | Local table register selector |
| ldt_base | output | 32 | Cached local table base |
| ldt_limit | output | 16 | Cached local table limit |

## Verification
A write to the global table register can fall in the same cycle in which a command is accepted and its address and bound are worked out. The bench raises `gtr_we` with a new base on the same falling edge on which it raises `cmd_valid` against an idle block. The fetch must then read from the old base, and a second command must read from the new one. Memory stalls come from a pseudo-random ready pattern. Every request address is checked against a queue of expected addresses filled by the driver.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int SEL_W      = 16;
  localparam int WORD_W     = 32;
  localparam int TBL_LIM_W  = 16;
  localparam int GTR_W      = WORD_W + TBL_LIM_W;
  localparam int DLIM_W     = 20;
  localparam int ATTR_W     = 12;
  localparam int RPL_W      = 2;
  localparam int ENT_SHIFT  = 3;
  localparam int IDX_W      = SEL_W - ENT_SHIFT;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [WORD_W-1:0] base;
    logic [DLIM_W-1:0] limit;
    logic [ATTR_W-1:0] attr;
  } seg_cache_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_LO, S_WAIT_LO, S_REQ_HI, S_WAIT_HI
  } fetch_st_e;
endpackage

// File: rtl/sdf_sel_decode.sv
module sdf_sel_decode
  import sdf_pkg::*;
(
  input  logic [IDX_W-1:0]     idx,
  input  logic                 ti,
  input  logic                 for_ltr,
  input  logic [WORD_W-1:0]    gdt_base,
  input  logic [TBL_LIM_W-1:0] gdt_lim,
  input  logic [IDX_W-1:0]     ldt_idx,
  input  logic [WORD_W-1:0]    ldt_base,
  input  logic [TBL_LIM_W-1:0] ldt_lim,
  output logic [WORD_W-1:0]    desc_addr,
  output logic                 fault,
  output logic                 null_ltr
);
  logic                 use_local;
  logic [WORD_W-1:0]    tbl_base;
  logic [TBL_LIM_W-1:0] tbl_lim;
  logic [TBL_LIM_W-1:0] last_byte;
  logic                 out_of_bounds;
  logic                 ldt_is_null;

  always_comb begin
    use_local     = ti && !for_ltr;
    tbl_base      = use_local ? ldt_base : gdt_base;
    tbl_lim       = use_local ? ldt_lim  : gdt_lim;
    last_byte     = {idx, {ENT_SHIFT{1'b1}}};
    out_of_bounds = last_byte > tbl_lim;
    ldt_is_null   = (ldt_idx == '0);
    null_ltr      = for_ltr && (idx == '0);
    fault         = !null_ltr && (out_of_bounds || (use_local && ldt_is_null));
    desc_addr     = tbl_base + WORD_W'({idx, {ENT_SHIFT{1'b0}}});
  end
endmodule

// File: rtl/sdf_read_seq.sv
module sdf_read_seq
  import sdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_addr,
  output logic              idle,
  output logic              fin,
  output logic [WORD_W-1:0] word_lo,
  output logic [WORD_W-1:0] word_hi,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  fetch_st_e         state_q, state_d;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] lo_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (start)         state_d = S_REQ_LO;
      S_REQ_LO:  if (mem_req_ready) state_d = S_WAIT_LO;
      S_WAIT_LO: if (mem_rsp_valid) state_d = S_REQ_HI;
      S_REQ_HI:  if (mem_req_ready) state_d = S_WAIT_HI;
      S_WAIT_HI: if (mem_rsp_valid) state_d = S_IDLE;
      default:                      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start)
        addr_q <= start_addr;
      else if (state_q == S_REQ_LO && mem_req_ready)
        addr_q <= addr_q + WORD_W'(WORD_BYTES);
      if (state_q == S_WAIT_LO && mem_rsp_valid)
        lo_q <= mem_rsp_data;
    end
  end

  assign idle          = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_REQ_LO) || (state_q == S_REQ_HI);
  assign mem_req_addr  = addr_q;
  assign fin           = (state_q == S_WAIT_HI) && mem_rsp_valid;
  assign word_lo       = lo_q;
  assign word_hi       = mem_rsp_data;
endmodule

// File: rtl/sdf_seg_file.sv
module sdf_seg_file
  import sdf_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int SIW      = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [SIW-1:0] widx,
  input  seg_cache_t     wdata,
  input  logic [SIW-1:0] ridx,
  output seg_cache_t     rdata
);
  seg_cache_t ent_arr [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
    seg_cache_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= '0;
      else if (we && widx == SIW'(g))
        ent_q <= wdata;
    end
    assign ent_arr[g] = ent_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SEGS; i++)
      if (ridx == SIW'(i)) rdata = ent_arr[i];
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import sdf_pkg::*;
#(
  parameter  int NUM_SEGS  = 6,
  localparam int SEG_IDX_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gtr_we,
  input  logic [GTR_W-1:0]     gtr_wdata,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_ltr,
  input  logic [SEG_IDX_W-1:0] cmd_seg,
  input  logic [SEL_W-1:0]     cmd_sel,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [WORD_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 done,
  output logic                 fault,
  input  logic [SEG_IDX_W-1:0] seg_rd_idx,
  output logic [SEL_W-1:0]     seg_rd_sel,
  output logic [RPL_W-1:0]     seg_rd_rpl,
  output logic [WORD_W-1:0]    seg_rd_base,
  output logic [DLIM_W-1:0]    seg_rd_limit,
  output logic                 seg_rd_gran,
  output logic [ATTR_W-1:0]    seg_rd_attr,
  output logic [SEL_W-1:0]     ldt_sel,
  output logic [WORD_W-1:0]    ldt_base,
  output logic [TBL_LIM_W-1:0] ldt_limit
);
  logic [WORD_W-1:0]    gdt_base_q;
  logic [TBL_LIM_W-1:0] gdt_lim_q;
  logic [SEL_W-1:0]     ldt_sel_q;
  logic [WORD_W-1:0]    ldt_base_q;
  logic [TBL_LIM_W-1:0] ldt_lim_q;
  logic                 pend_ltr_q;
  logic [SEG_IDX_W-1:0] pend_seg_q;
  logic [SEL_W-1:0]     pend_sel_q;
  logic                 done_q, fault_q;

  logic [WORD_W-1:0] dec_addr;
  logic              dec_fault, dec_null;
  logic              seq_idle, seq_fin, accept, start;
  logic [WORD_W-1:0] word_lo, word_hi;
  seg_cache_t        seg_wdata, seg_rdata;

  sdf_sel_decode u_decode (
    .idx       (cmd_sel[SEL_W-1:ENT_SHIFT]),
    .ti        (cmd_sel[RPL_W]),
    .for_ltr   (cmd_ltr),
    .gdt_base  (gdt_base_q),
    .gdt_lim   (gdt_lim_q),
    .ldt_idx   (ldt_sel_q[SEL_W-1:ENT_SHIFT]),
    .ldt_base  (ldt_base_q),
    .ldt_lim   (ldt_lim_q),
    .desc_addr (dec_addr),
    .fault     (dec_fault),
    .null_ltr  (dec_null)
  );

  assign cmd_ready = seq_idle;
  assign accept    = cmd_valid && seq_idle;
  assign start     = accept && !dec_fault && !dec_null;

  sdf_read_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_addr    (dec_addr),
    .idle          (seq_idle),
    .fin           (seq_fin),
    .word_lo       (word_lo),
    .word_hi       (word_hi),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gdt_base_q <= '0;
      gdt_lim_q  <= '0;
      ldt_sel_q  <= '0;
      ldt_base_q <= '0;
      ldt_lim_q  <= '0;
      pend_ltr_q <= 1'b0;
      pend_seg_q <= '0;
      pend_sel_q <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      if (gtr_we) begin
        gdt_lim_q  <= gtr_wdata[TBL_LIM_W-1:0];
        gdt_base_q <= gtr_wdata[GTR_W-1:TBL_LIM_W];
      end
      if (accept) begin
        pend_ltr_q <= cmd_ltr;
        pend_seg_q <= cmd_seg;
        pend_sel_q <= cmd_sel;
      end
      if (accept && dec_null) begin
        ldt_sel_q  <= cmd_sel;
        ldt_base_q <= '0;
        ldt_lim_q  <= '0;
      end else if (seq_fin && pend_ltr_q) begin
        ldt_sel_q  <= pend_sel_q;
        ldt_base_q <= word_lo;
        ldt_lim_q  <= word_hi[TBL_LIM_W-1:0];
      end
      done_q  <= seq_fin || (accept && dec_null);
      fault_q <= accept && dec_fault;
    end
  end

  always_comb begin
    seg_wdata.sel   = pend_sel_q;
    seg_wdata.base  = word_lo;
    seg_wdata.limit = word_hi[DLIM_W-1:0];
    seg_wdata.attr  = word_hi[WORD_W-1 -: ATTR_W];
  end

  sdf_seg_file #(.NUM_SEGS(NUM_SEGS), .SIW(SEG_IDX_W)) u_segs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (seq_fin && !pend_ltr_q),
    .widx  (pend_seg_q),
    .wdata (seg_wdata),
    .ridx  (seg_rd_idx),
    .rdata (seg_rdata)
  );

  assign done         = done_q;
  assign fault        = fault_q;
  assign seg_rd_sel   = seg_rdata.sel;
  assign seg_rd_rpl   = seg_rdata.sel[RPL_W-1:0];
  assign seg_rd_base  = seg_rdata.base;
  assign seg_rd_limit = seg_rdata.limit;
  assign seg_rd_gran  = seg_rdata.attr[0];
  assign seg_rd_attr  = seg_rdata.attr;
  assign ldt_sel      = ldt_sel_q;
  assign ldt_base     = ldt_base_q;
  assign ldt_limit    = ldt_lim_q;
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker
  import sdf_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_ready,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [WORD_W-1:0]    mem_req_addr,
  input logic                 done,
  input logic                 fault,
  input logic [SEL_W-1:0]     ldt_sel,
  input logic [WORD_W-1:0]    ldt_base,
  input logic [TBL_LIM_W-1:0] ldt_limit
);
  logic              second_q;
  logic [WORD_W-1:0] first_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_q     <= 1'b0;
      first_addr_q <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      second_q <= !second_q;
      if (!second_q) first_addr_q <= mem_req_addr;
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_high_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && second_q |-> mem_req_addr == first_addr_q + WORD_W'(WORD_BYTES));

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready && !fault);

  p_fault_keeps_ldt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(ldt_sel) && $stable(ldt_base) && $stable(ldt_limit));
endmodule

bind seg_desc_fetch sdf_checker u_sdf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .fault         (fault),
  .ldt_sel       (ldt_sel),
  .ldt_base      (ldt_base),
  .ldt_limit     (ldt_limit)
);

// File: tb/seg_desc_fetch_bench.sv
module seg_desc_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gtr_we = 1'b0;
  logic [47:0] gtr_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_ltr = 1'b0;
  logic [2:0]  cmd_seg = '0;
  logic [15:0] cmd_sel = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [2:0]  seg_rd_idx = '0;
  logic [15:0] seg_rd_sel;
  logic [1:0]  seg_rd_rpl;
  logic [31:0] seg_rd_base;
  logic [19:0] seg_rd_limit;
  logic        seg_rd_gran;
  logic [11:0] seg_rd_attr;
  logic [15:0] ldt_sel;
  logic [31:0] ldt_base;
  logic [15:0] ldt_limit;

  always #2 clk = ~clk;

  seg_desc_fetch u_seg_desc_fetch (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  localparam int K_DONE = 1;
  localparam int K_FAULT = 2;
  int          exp_kind [$];
  string       exp_tag [$];
  logic [31:0] exp_addr [$];
  logic [31:0] ovr [logic [31:0]];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (ovr.exists(a)) return ovr[a];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // memory model: random ready, one response per handshake, address scoreboard
  initial begin
    bit hs = 1'b0;
    bit pend = 1'b0;
    int lat = 0;
    logic [31:0] hs_addr = '0;
    logic [31:0] pend_a = '0;
    logic [7:0] lfsr = 8'hA7;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs) begin
        if (exp_addr.size() == 0) chk(1'b0, "R10 unexpected read", hs_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_addr.pop_front();
          eq("R2 read address", hs_addr, e);
        end
        pend = 1'b1;
        pend_a = hs_addr;
        lat = (lfsr[2:1] == 2'b00) ? 2 : 0;
      end
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_word(pend_a);
          pend = 1'b0;
        end else lat--;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[3];
      hs = mem_req_valid && mem_req_ready;
      hs_addr = mem_req_addr;
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (done || fault)) begin
        int act;
        act = (done ? 1 : 0) + (fault ? 2 : 0);
        if (exp_kind.size() == 0) chk(1'b0, "R11 unexpected pulse", act, 0);
        else begin
          int k;
          string t;
          k = exp_kind.pop_front();
          t = exp_tag.pop_front();
          eq(t, act, k);
        end
      end
    end
  end

  task automatic expect_cmd(input int kind, input string tag, input logic [31:0] daddr, input bit reads);
    exp_kind.push_back(kind);
    exp_tag.push_back(tag);
    if (reads) begin
      exp_addr.push_back(daddr);
      exp_addr.push_back(daddr + 32'd4);
    end
  endtask

  task automatic wait_empty();
    while (exp_kind.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input bit ltr, input int seg, input logic [15:0] sel,
                       input int kind, input string tag, input logic [31:0] daddr);
    expect_cmd(kind, tag, daddr, kind == K_DONE && !(ltr && sel[15:3] == 0));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ltr = ltr; cmd_seg = 3'(seg); cmd_sel = sel;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_empty();
  endtask

  task automatic write_gdt(input logic [31:0] base, input logic [15:0] lim);
    @(negedge clk);
    gtr_we = 1'b1; gtr_wdata = {base, lim};
    @(negedge clk);
    gtr_we = 1'b0;
  endtask

  task automatic check_seg(input int seg, input string tag, input logic [15:0] sel,
                           input logic [31:0] base, input logic [31:0] w1);
    seg_rd_idx = 3'(seg);
    #1;
    eq({tag, " sel"}, seg_rd_sel, sel);
    eq({tag, " rpl R1"}, seg_rd_rpl, sel[1:0]);
    eq({tag, " base"}, seg_rd_base, base);
    eq({tag, " limit R4"}, seg_rd_limit, w1[19:0]);
    eq({tag, " attr R4"}, seg_rd_attr, w1[31:20]);
    eq({tag, " gran R4"}, seg_rd_gran, w1[20]);
  endtask

  task automatic check_fetched(input int seg, input string tag, input logic [15:0] sel, input logic [31:0] a);
    check_seg(seg, tag, sel, mem_word(a), mem_word(a + 32'd4));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    eq("R12 cmd_ready", cmd_ready, 1);
    eq("R12 mem_req_valid", mem_req_valid, 0);
    eq("R12 ldt_sel", ldt_sel, 0);
    eq("R12 ldt_base", ldt_base, 0);
    eq("R12 ldt_limit", ldt_limit, 0);
    check_seg(1, "R12 slot1", 16'h0, 32'h0, 32'h0);

    // R12 zero global limit makes every global access fault
    issue(0, 1, 16'h0008, K_FAULT, "R12 zero global limit fault", 0);
    check_seg(1, "R5 slot1 untouched", 16'h0, 32'h0, 32'h0);

    write_gdt(32'h0010_0000, 16'h00FF);

    // R1 R2 R4 global loads, granularity set and clear
    ovr[32'h0010_0010] = 32'hCAFE_0000; ovr[32'h0010_0014] = 32'h9A1F_ABCD;
    issue(0, 0, 16'h0013, K_DONE, "R2 global load", 32'h0010_0010);
    check_seg(0, "R1", 16'h0013, 32'hCAFE_0000, 32'h9A1F_ABCD);
    ovr[32'h0010_0038] = 32'h0001_2000; ovr[32'h0010_003C] = 32'h4920_1234;
    issue(0, 2, 16'h0039, K_DONE, "R4 gran clear load", 32'h0010_0038);
    check_seg(2, "R4", 16'h0039, 32'h0001_2000, 32'h4920_1234);

    // R5 bound: last entry fits, next one faults
    issue(0, 3, 16'h00F8, K_DONE, "R5 last entry", 32'h0010_00F8);
    check_fetched(3, "R5 last entry", 16'h00F8, 32'h0010_00F8);
    issue(0, 3, 16'h0100, K_FAULT, "R5 past limit fault", 0);
    check_fetched(3, "R5 slot unchanged", 16'h00F8, 32'h0010_00F8);

    // R6 local access with null local register
    issue(0, 4, 16'h000C, K_FAULT, "R6 null local fault", 0);
    check_seg(4, "R6 slot4 untouched", 16'h0, 32'h0, 32'h0);

    // R7 local register load through global entry 5, bit 2 set but ignored
    ovr[32'h0010_0028] = 32'h0020_0000; ovr[32'h0010_002C] = 32'h0000_003F;
    issue(1, 0, 16'h002C, K_DONE, "R7 local register load", 32'h0010_0028);
    eq("R7 ldt_sel", ldt_sel, 16'h002C);
    eq("R7 ldt_base", ldt_base, 32'h0020_0000);
    eq("R7 ldt_limit", ldt_limit, 16'h003F);

    // R3 local accesses
    issue(0, 4, 16'h001E, K_DONE, "R3 local load", 32'h0020_0018);
    check_fetched(4, "R3", 16'h001E, 32'h0020_0018);
    issue(0, 5, 16'h0044, K_FAULT, "R3 local past limit fault", 0);
    issue(0, 5, 16'h003C, K_DONE, "R3 local last entry", 32'h0020_0038);
    check_fetched(5, "R3 last", 16'h003C, 32'h0020_0038);

    // R8 null local register load, then R6 again
    issue(1, 0, 16'h0003, K_DONE, "R8 null local register load", 0);
    eq("R8 ldt_sel", ldt_sel, 16'h0003);
    eq("R8 ldt_base", ldt_base, 0);
    eq("R8 ldt_limit", ldt_limit, 0);
    issue(0, 5, 16'h003C, K_FAULT, "R6 fault after null reload", 0);
    check_fetched(5, "R6 slot5 unchanged", 16'h003C, 32'h0020_0038);

    // R9 global register write in the acceptance cycle
    expect_cmd(K_DONE, "R9 same-cycle write", 32'h0010_0020, 1'b1);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_ltr = 1'b0; cmd_seg = 3'd0; cmd_sel = 16'h0020;
    gtr_we = 1'b1; gtr_wdata = {32'h0030_0000, 16'h00FF};
    @(negedge clk);
    cmd_valid = 1'b0; gtr_we = 1'b0;
    wait_empty();
    check_fetched(0, "R9 old base", 16'h0020, 32'h0010_0020);
    issue(0, 1, 16'h0020, K_DONE, "R9 new base", 32'h0030_0020);
    check_fetched(1, "R9 new base", 16'h0020, 32'h0030_0020);

    // R11 command held while busy
    expect_cmd(K_DONE, "R11 first", 32'h0030_0050, 1'b1);
    expect_cmd(K_DONE, "R11 held", 32'h0030_0058, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ltr = 1'b0; cmd_seg = 3'd2; cmd_sel = 16'h0050;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_seg = 3'd3; cmd_sel = 16'h0058;
    eq("R11 ready low while busy", cmd_ready, 0);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_empty();
    check_fetched(2, "R11 first", 16'h0050, 32'h0030_0050);
    check_fetched(3, "R11 held", 16'h0058, 32'h0030_0058);

    repeat (5) @(negedge clk);
    eq("R10 all reads consumed", exp_addr.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R11 watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule